// File: doc/BRIEF.md
# Receive Line Alarm and Shutdown Unit

This block watches the recovered receive stream of a 2.048 Mbit/s line interface and raises two active-low alarms. A loss-of-signal alarm is formed from a digital run-of-zeros detector working on the recovered data, combined with an analog signal-loss flag that comes from the line front end. A loss-of-clock alarm comes from a watchdog that counts activity of the receive clock in fixed windows of a free-running reference clock. The watchdog's result is only shown while the shutdown option is enabled and signal is lost.

The block also owns the receive outputs toward the terminal side. It passes the receive clock and the registered data rails through, with an optional inverted polarity in dual-rail mode. On signal loss it holds or clears the data. When shutdown is enabled it forces the clock and data to fixed idle levels. An active-low alarm-test input forces every alarm output into its alarm state and leaves the data path alone.

Top module: `rx_alarm_unit`

## Requirements
- R1: Loss of signal (los_n_o low) is raised by the digital detector once more than ZERO_LIMIT consecutive zero bits have been sampled on rising receive clock edges. Exactly ZERO_LIMIT zeros do not raise it.
- R2: Any mark clears the zero run. In single-rail mode a mark is rx_p_i high; in dual-rail mode it is rx_p_i or rx_n_i high. The run count saturates, so a run of any length keeps the alarm until the next mark.
- R3: los_n_o is low while the digital detector or ana_los_i is active. While loop_local_i is high, ana_los_i is ignored.
- R4: Receive data rails are registered on the rising receive clock edge, one bit of latency. While the digital detector is active the data reads zero. While an effective analog loss is present the rails hold their last value.
- R5: The inverted polarity is active when dual_rail_i=1 and inv_mode_i=1. In that case rx_clk_o, rx_p_o and rx_n_o are inverted. In single-rail mode rx_n_o is 0 and inv_mode_i has no effect.
- R6: With shutdown_i=1 and loss of signal active, rx_clk_o is driven 1 and the data rails 0. Under inverted polarity rx_clk_o is driven 0 and the data rails 1. In single-rail mode rx_n_o stays 0.
- R7: loc_n_o is low only while shutdown_i=1, loss of signal is active, and the reference-clocked watchdog has declared the receive clock dead. A stopped receive clock with shutdown disabled gives no loss-of-clock alarm.
- R8: The watchdog declares the clock dead after a reference window of WIN_LEN cycles with no synchronised activity. It clears after CLEAR_WINS consecutive active windows. The output clock is stopped when forced, and the watchdog then raises the alarm within a few windows.
- R9: With alarm_test_ni low, los_n_o=0, loc_n_o=0 and vio_o=1 while data still flows. Otherwise vio_o follows vio_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Free-running 2.048 MHz reference clock |
| rx_clk_i | input | 1 | Recovered receive clock |
| rx_p_i | input | 1 | Recovered data, positive rail (single-rail data) |
| rx_n_i | input | 1 | Recovered data, negative rail |
| vio_i | input | 1 | Violation flag from the decoder |
| ana_los_i | input | 1 | Analog loss-of-signal flag, active high |
| shutdown_i | input | 1 | Shutdown enable |
| alarm_test_ni | input | 1 | Alarm test, active low |
| loop_local_i | input | 1 | Full local loopback active |
| dual_rail_i | input | 1 | 1 selects dual-rail mode |
| inv_mode_i | input | 1 | 1 selects inverted polarity (dual-rail only) |
| rx_clk_o | output | 1 | Receive clock toward the terminal |
| rx_p_o | output | 1 | Receive data / positive rail |
| rx_n_o | output | 1 | Receive negative rail |
| vio_o | output | 1 | Violation output |
| los_n_o | output | 1 | Loss of signal, active low |
| loc_n_o | output | 1 | Loss of clock, active low |

## Verification
The bench builds the block with ZERO_LIMIT=6 and leaves the watchdog at WIN_LEN=4 and CLEAR_WINS=2. The short limit lets it sweep every zero-run length from one to three past the threshold, each started after a mark, so both sides of the boundary and saturation are seen. All four rail/polarity combinations are swept, each in both the pass-through and the shutdown-forced state. The small watchdog windows bring alarm raise, gated release and clearing after active windows into a few dozen reference cycles.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef struct packed {
    logic dual;
    logic inv;
  } rail_mode_t;

  function automatic logic mode_inverted(rail_mode_t m);
    return m.dual & m.inv;
  endfunction
endpackage

// File: rtl/rxa_zero_run.sv
module rxa_zero_run #(
  parameter int ZERO_LIMIT = 32
) (
  input  logic rx_clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic dig_los_o
);
  localparam int SAT = ZERO_LIMIT + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge rx_clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (mark_i)         cnt_q <= '0;
    else if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
  end

  assign dig_los_o = (cnt_q == SAT_V);
endmodule

// File: rtl/rxa_data_hold.sv
module rxa_data_hold #(
  parameter int RAILS = 2
) (
  input  logic             rx_clk_i,
  input  logic             rst_ni,
  input  logic [RAILS-1:0] d_i,
  input  logic             hold_i,
  input  logic             clear_i,
  output logic [RAILS-1:0] d_o
);
  logic [RAILS-1:0] d_q;

  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    always_ff @(posedge rx_clk_i or negedge rst_ni) begin
      if (!rst_ni)      d_q[g] <= 1'b0;
      else if (!hold_i) d_q[g] <= d_i[g];
    end
    assign d_o[g] = d_q[g] & ~clear_i;
  end
endmodule

// File: rtl/rxa_clk_watch.sv
module rxa_clk_watch #(
  parameter int WIN_LEN    = 4,
  parameter int CLEAR_WINS = 2,
  parameter int DIV_W      = 2,
  parameter int SYNC_N     = 2
) (
  input  logic rst_ni,
  input  logic rx_clk_i,
  input  logic run_i,
  input  logic ref_clk_i,
  output logic dead_o
);
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int GW = $clog2(CLEAR_WINS + 1);
  localparam logic [WW-1:0] WIN_END = WW'(WIN_LEN - 1);
  localparam logic [GW-1:0] GOOD_END = GW'(CLEAR_WINS - 1);

  // receive-clock side: divider advances only while the output clock runs
  logic [DIV_W-1:0] div_q;
  always_ff @(posedge rx_clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end

  // reference side
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              chg;
  logic [WW-1:0]     win_q;
  logic              seen_q;
  logic [GW-1:0]     good_q;
  logic              dead_q;
  logic              win_end, act;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], div_q[DIV_W-1]};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign chg     = sync_q[SYNC_N-1] ^ prev_q;
  assign win_end = (win_q == WIN_END);
  assign act     = seen_q | chg;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      good_q <= '0;
      dead_q <= 1'b0;
    end else if (win_end) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      if (!act) begin
        dead_q <= 1'b1;
        good_q <= '0;
      end else if (dead_q) begin
        if (good_q == GOOD_END) begin
          dead_q <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else begin
      win_q  <= win_q + 1'b1;
      seen_q <= act;
    end
  end

  assign dead_o = dead_q;
endmodule

// File: rtl/rx_alarm_unit.sv
module rx_alarm_unit #(
  parameter int ZERO_LIMIT = 32,
  parameter int WIN_LEN    = 4,
  parameter int CLEAR_WINS = 2,
  parameter int DIV_W      = 2,
  parameter int SYNC_N     = 2
) (
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic rx_clk_i,
  input  logic rx_p_i,
  input  logic rx_n_i,
  input  logic vio_i,
  input  logic ana_los_i,
  input  logic shutdown_i,
  input  logic alarm_test_ni,
  input  logic loop_local_i,
  input  logic dual_rail_i,
  input  logic inv_mode_i,
  output logic rx_clk_o,
  output logic rx_p_o,
  output logic rx_n_o,
  output logic vio_o,
  output logic los_n_o,
  output logic loc_n_o
);
  import rxa_pkg::*;

  rail_mode_t mode;
  logic       inv, mark, dig_los, ana_eff, los, forced, wd_dead;
  logic [1:0] rail_d;

  assign mode    = '{dual: dual_rail_i, inv: inv_mode_i};
  assign inv     = mode_inverted(mode);
  assign mark    = rx_p_i | (dual_rail_i & rx_n_i);
  assign ana_eff = ana_los_i & ~loop_local_i;
  assign los     = dig_los | ana_eff;
  assign forced  = shutdown_i & los;

  rxa_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_zr (
    .rx_clk_i (rx_clk_i),
    .rst_ni   (rst_ni),
    .mark_i   (mark),
    .dig_los_o(dig_los)
  );

  rxa_data_hold #(.RAILS(2)) u_dh (
    .rx_clk_i(rx_clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({rx_n_i, rx_p_i}),
    .hold_i  (ana_eff),
    .clear_i (dig_los),
    .d_o     (rail_d)
  );

  rxa_clk_watch #(
    .WIN_LEN   (WIN_LEN),
    .CLEAR_WINS(CLEAR_WINS),
    .DIV_W     (DIV_W),
    .SYNC_N    (SYNC_N)
  ) u_cw (
    .rst_ni   (rst_ni),
    .rx_clk_i (rx_clk_i),
    .run_i    (~forced),
    .ref_clk_i(ref_clk_i),
    .dead_o   (wd_dead)
  );

  always_comb begin
    if (forced) begin
      rx_clk_o = ~inv;
      rx_p_o   = inv;
      rx_n_o   = dual_rail_i & inv;
    end else begin
      rx_clk_o = rx_clk_i ^ inv;
      rx_p_o   = rail_d[0] ^ inv;
      rx_n_o   = dual_rail_i & (rail_d[1] ^ inv);
    end
  end

  assign los_n_o = alarm_test_ni & ~los;
  assign loc_n_o = alarm_test_ni & ~(wd_dead & forced);
  assign vio_o   = ~alarm_test_ni | vio_i;
endmodule

// File: rtl/rx_alarm_unit_chk.sv
module rx_alarm_unit_chk (
  input logic rst_ni,
  input logic ref_clk_i,
  input logic rx_clk_i,
  input logic rx_p_i,
  input logic rx_n_i,
  input logic dual_rail_i,
  input logic inv_mode_i,
  input logic shutdown_i,
  input logic alarm_test_ni,
  input logic loop_local_i,
  input logic dig_los,
  input logic wd_dead,
  input logic rx_clk_o,
  input logic vio_o,
  input logic los_n_o,
  input logic loc_n_o
);
  logic chk_mark;
  assign chk_mark = rx_p_i | (dual_rail_i & rx_n_i);

  // R2: a mark always ends the digital alarm
  a_r2_mark_clears: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    chk_mark |=> !dig_los);

  // R2: saturation keeps the alarm through further zeros
  a_r2_sat_holds: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (dig_los && !chk_mark) |=> dig_los);

  // R3: in local loopback only the digital detector may drive the alarm
  a_r3_loop_digital_only: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (loop_local_i && !dig_los && alarm_test_ni) |-> los_n_o);

  // R6: forced output clock level
  a_r6_forced_clock: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (shutdown_i && !los_n_o && alarm_test_ni) |-> (rx_clk_o == !(dual_rail_i && inv_mode_i)));

  // R7: loss of clock needs shutdown and loss of signal
  a_r7_loc_qualified: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!loc_n_o && alarm_test_ni) |-> (shutdown_i && !los_n_o && wd_dead));

  // R9: alarm test forces the alarm outputs
  a_r9_alarm_test: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !alarm_test_ni |-> (!los_n_o && !loc_n_o && vio_o));
endmodule

bind rx_alarm_unit rx_alarm_unit_chk u_chk (
  .rst_ni       (rst_ni),
  .ref_clk_i    (ref_clk_i),
  .rx_clk_i     (rx_clk_i),
  .rx_p_i       (rx_p_i),
  .rx_n_i       (rx_n_i),
  .dual_rail_i  (dual_rail_i),
  .inv_mode_i   (inv_mode_i),
  .shutdown_i   (shutdown_i),
  .alarm_test_ni(alarm_test_ni),
  .loop_local_i (loop_local_i),
  .dig_los      (dig_los),
  .wd_dead      (wd_dead),
  .rx_clk_o     (rx_clk_o),
  .vio_o        (vio_o),
  .los_n_o      (los_n_o),
  .loc_n_o      (loc_n_o)
);

// File: tb/sim_rx_alarm_unit.sv
module sim_rx_alarm_unit;
  localparam int LIM = 6;

  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic rx_clk = 1'b0;
  logic rx_run = 1'b1;
  logic rx_p = 1'b0, rx_n = 1'b0, vio_in = 1'b0, ana = 1'b0, sd = 1'b0;
  logic atest_n = 1'b1, loop_l = 1'b0, dual = 1'b0, inv = 1'b0;
  logic clk_o, p_o, n_o, vio_o, los_n, loc_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  rx_alarm_unit #(.ZERO_LIMIT(LIM)) u0 (
    .rst_ni(rst_n), .ref_clk_i(ref_clk), .rx_clk_i(rx_clk),
    .rx_p_i(rx_p), .rx_n_i(rx_n), .vio_i(vio_in), .ana_los_i(ana),
    .shutdown_i(sd), .alarm_test_ni(atest_n), .loop_local_i(loop_l),
    .dual_rail_i(dual), .inv_mode_i(inv),
    .rx_clk_o(clk_o), .rx_p_o(p_o), .rx_n_o(n_o), .vio_o(vio_o),
    .los_n_o(los_n), .loc_n_o(loc_n)
  );

  always #5 ref_clk = ~ref_clk;

  initial begin
    #2;
    forever begin
      #5;
      if (rx_run) rx_clk = ~rx_clk;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge rx_clk);
    rx_p = p;
    rx_n = n;
    @(posedge rx_clk);
    #1;
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic i2;
    ref_wait(3);
    rst_n = 1'b1;
    ref_wait(2);
    check("R1 reset los", los_n, 1'b1);
    check("R7 reset loc", loc_n, 1'b1);
    check("R9 reset vio", vio_o, 1'b0);

    // R1/R2: every run length around the limit, single rail
    for (int n = 1; n <= LIM + 3; n++) begin
      send_bit(1'b1, 1'b0);
      check("R2 mark clears los", los_n, 1'b1);
      check("R4 data registered", p_o, 1'b1);
      for (int k = 1; k <= n; k++) begin
        send_bit(1'b0, 1'b0);
        check("R1 zero run", los_n, !(k > LIM));
      end
    end
    for (int k = 0; k < 40; k++) send_bit(1'b0, 1'b0);
    check("R2 saturated run keeps los", los_n, 1'b0);
    check("R4 digital los data low", p_o, 1'b0);
    send_bit(1'b1, 1'b0);
    check("R2 mark after long run", los_n, 1'b1);

    // R2 dual rail: n-rail marks also count
    dual = 1'b1;
    send_bit(1'b0, 1'b1);
    for (int k = 0; k < LIM; k++) send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b1);
    check("R2 n-rail mark", los_n, 1'b1);
    check("R4 n rail data", n_o, 1'b1);
    for (int k = 0; k < LIM; k++) send_bit(1'b0, 1'b0);
    check("R1 exactly limit", los_n, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R1 limit plus one", los_n, 1'b0);
    send_bit(1'b1, 1'b0);
    dual = 1'b0;

    // R3/R4: analog loss, hold, loopback
    send_bit(1'b1, 1'b0);
    ana = 1'b1;
    #1;
    check("R3 analog los", los_n, 1'b0);
    send_bit(1'b0, 1'b0);
    check("R4 analog hold", p_o, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R4 analog hold 2", p_o, 1'b1);
    loop_l = 1'b1;
    #1;
    check("R3 loopback ignores analog", los_n, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R4 data resumes", p_o, 1'b0);
    loop_l = 1'b0;
    ana = 1'b0;
    send_bit(1'b1, 1'b0);

    // R5/R6: rail and polarity modes
    for (int m = 0; m < 4; m++) begin
      dual = m[0];
      inv = m[1];
      i2 = dual & inv;
      send_bit(1'b1, 1'b0);
      check("R5 p polarity", p_o, 1'b1 ^ i2);
      check("R5 n polarity", n_o, dual ? i2 : 1'b0);
      check("R5 clk polarity", clk_o, 1'b1 ^ i2);
      sd = 1'b1;
      ana = 1'b1;
      #1;
      check("R6 forced clk", clk_o, !i2);
      check("R6 forced p", p_o, i2);
      check("R6 forced n", n_o, dual ? i2 : 1'b0);
      ref_wait(3);
      check("R6 forced clk stays", clk_o, !i2);
      ana = 1'b0;
      sd = 1'b0;
      ref_wait(30);
    end
    dual = 1'b0;
    inv = 1'b0;

    // R7/R8: loss of clock
    sd = 1'b1;
    ana = 1'b1;
    #1;
    check("R8 no immediate loc", loc_n, 1'b1);
    ref_wait(30);
    check("R8 loc raised", loc_n, 1'b0);
    ana = 1'b0;
    #1;
    check("R7 loc gated by los", loc_n, 1'b1);
    ref_wait(30);
    ana = 1'b1;
    #1;
    check("R8 loc cleared by active windows", loc_n, 1'b1);
    ref_wait(30);
    check("R8 loc raised again", loc_n, 1'b0);
    ana = 1'b0;
    sd = 1'b0;
    ref_wait(30);
    rx_run = 1'b0;
    ref_wait(40);
    check("R7 stopped clock no shutdown", loc_n, 1'b1);
    check("R7 stopped clock los", los_n, 1'b1);
    rx_run = 1'b1;
    ref_wait(30);

    // R9: alarm test
    vio_in = 1'b1;
    #1;
    check("R9 vio pass", vio_o, 1'b1);
    vio_in = 1'b0;
    atest_n = 1'b0;
    #1;
    check("R9 test los", los_n, 1'b0);
    check("R9 test loc", loc_n, 1'b0);
    check("R9 test vio", vio_o, 1'b1);
    send_bit(1'b1, 1'b0);
    check("R9 data unaffected 1", p_o, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R9 data unaffected 0", p_o, 1'b0);
    atest_n = 1'b1;
    #1;
    check("R9 release vio", vio_o, 1'b0);
    check("R9 release los", los_n, 1'b1);

    finish_run();
  end
endmodule